// File: doc/BRIEF.md
# Byte-Wide SPI Master with Status Flags

This block is a serial-peripheral master that a processor drives through a small register set. It has three registers: a control byte, a status byte that software can only read, and a data byte. When software writes the data register while the block is enabled and idle, a full-duplex 8-bit exchange starts. The block drives the serial clock and the outgoing data line, and it samples the incoming data line. The divider, clock polarity and clock phase are set in the control byte.

When the last bit has been exchanged, the block sets a completion flag. It can also raise an interrupt request. A data write that arrives while an exchange is running is dropped, and a collision flag is set. Software clears the flags in two steps. A status read records the flags that are set at that moment. A later read or write of the data register then clears only the recorded flags. A flag that is set after the status read survives.

The register port has no ready signal and no back-pressure. An access takes effect in the single cycle in which `bus_sel` is high. Read data is valid in that same cycle, and any side effect of the access lands at the next rising clock edge.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, the control byte (address 0) and the status byte (address 1) read 0x00, `sck` is low and `irq` is low.
- R2: Control bits [1:0] choose the serial clock. Codes 0, 1, 2 and 3 give the system clock divided by 2, 4, 16 and 32, so `sck` changes level every 1, 2, 8 or 16 system cycles.
- R3: With the phase bit (control bit 2) clear, data is sent MSB first. Bit 7 is on `mosi` before the first `sck` edge, `miso` is sampled on each leading edge and `mosi` changes on each trailing edge.
- R4: With the phase bit set, `mosi` changes on each leading edge and `miso` is sampled on each trailing edge, MSB first.
- R5: `sck` rests at the level of the polarity bit (control bit 3). Each exchange makes exactly 16 `sck` edges and ends at the resting level.
- R6: A write to the data register (address 2) starts nothing while the enable bit (control bit 6) is clear.
- R7: A data write while an exchange is running sets the collision flag (status bit 6). The running byte is sent unchanged and the new value is dropped.
- R8: The end of an exchange sets the completion flag (status bit 7). `irq` is high whenever that flag and the interrupt-enable bit (control bit 7) are both set.
- R9: A status read records the flags that are set at that moment. The next data read or enabled data write clears exactly the recorded flags. A data access that has no recorded flags clears nothing, and the end of an exchange discards the record.
- R10: Writes to the status register have no effect. Status bits 5 and 3..0 read zero, and so does the mode-fault flag (bit 4).
- R11: A data read returns the byte received from `miso` during the last completed exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that each register access lasts one cycle and uses a decoded address. They also assume that a rate code is not changed during an exchange. The bench drives every access and every `miso` level on the falling clock edge, so inputs are stable at each sampling edge. It changes control settings only between exchanges. The slave model updates `miso` only after an `sck` edge on which the block does not sample.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 5;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_addr_e;

  // Half-period of sck in system cycles for each rate code.
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] code);
    case (code)
      2'd0:    half_period = DIV_W'(1);
      2'd1:    half_period = DIV_W'(2);
      2'd2:    half_period = DIV_W'(8);
      default: half_period = DIV_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt >= half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  // R2: with a half period above one cycle, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half > CW'(1) && $stable(half)) |=> !tick);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  input  logic         tick,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic         sck,
  output logic         mosi,
  output logic [W-1:0] rx_byte
);
  localparam int KW = $clog2(2 * W);
  localparam logic [KW-1:0] K_LAST = KW'(2 * W - 1);

  logic [KW-1:0] k;
  logic          tog;
  logic [W-1:0]  sh, rx;
  logic          lead, do_sample, do_shift;

  assign lead      = (k[0] == 1'b0);
  assign do_sample = tick && (cpha ? !lead : lead);
  assign do_shift  = tick && (cpha ? (lead && k != '0) : !lead);
  assign done      = tick && (k == K_LAST);
  assign rx_byte   = do_sample ? {rx[W-2:0], miso} : rx;
  assign sck       = cpol ^ tog;
  assign mosi      = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tog  <= 1'b0;
      k    <= '0;
      sh   <= '0;
      rx   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tog  <= 1'b0;
      k    <= '0;
      sh   <= din;
      rx   <= '0;
    end else if (tick) begin
      tog <= ~tog;
      k   <= k + KW'(1);
      if (do_sample) rx <= {rx[W-2:0], miso};
      if (do_shift)  sh <= {sh[W-2:0], 1'b0};
      if (done)      busy <= 1'b0;
    end
  end

  // R7: a new exchange is only launched from idle
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R5: the serial clock rests at the polarity level between exchanges
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
  // R8: completion ends the exchange
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] ctrl,
  output logic              start,
  output logic              irq
);
  logic              spif, wcol;
  logic [1:0]        snap;
  logic [BYTE_W-1:0] rxbuf;
  logic              stat_rd, data_rd, data_wr, data_acc, coll;
  logic [1:0]        clr;

  assign stat_rd  = bus_sel && !bus_wr && bus_addr == REG_STAT;
  assign data_rd  = bus_sel && !bus_wr && bus_addr == REG_DATA;
  assign data_wr  = bus_sel && bus_wr && bus_addr == REG_DATA && ctrl[6];
  assign data_acc = data_rd || data_wr;
  assign start    = data_wr && !busy;
  assign coll     = data_wr && busy;
  assign clr      = data_acc ? snap : 2'b00;
  assign irq      = spif && ctrl[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      spif  <= 1'b0;
      wcol  <= 1'b0;
      snap  <= 2'b00;
      rxbuf <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == REG_CTRL) ctrl <= bus_wdata;
      spif <= (spif && !clr[1]) || done;
      wcol <= (wcol && !clr[0]) || coll;
      if (done)          snap <= 2'b00;
      else if (stat_rd)  snap <= {spif, wcol};
      else if (data_acc) snap <= 2'b00;
      if (done) rxbuf <= rx_byte;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = ctrl;
      REG_STAT: bus_rdata = {spif, wcol, 6'b0};
      REG_DATA: bus_rdata = rxbuf;
      default:  bus_rdata = '0;
    endcase
  end

  // R8: the completion flag only rises after the engine finishes
  a_r8_spif_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(done));
  // R9: the completion flag only falls after a recorded data access
  a_r9_clear_after_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spif) |-> $past(data_acc && snap[1]));
  // R7: collision only arises while an exchange runs
  a_r7_wcol_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(busy));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [BYTE_W-1:0] ctrl, rx_byte;
  logic              start, busy, done, tick;
  logic [DIV_W-1:0]  half;

  assign half = half_period(ctrl[1:0]);

  spi_ctrl_regs u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .done, .rx_byte, .ctrl, .start, .irq
  );

  spi_clk_div #(.CW(DIV_W)) u_div (
    .clk, .rst_n, .run(busy), .half, .tick
  );

  spi_shift_engine #(.W(BYTE_W)) u_eng (
    .clk, .rst_n, .start, .din(bus_wdata), .tick,
    .cpol(ctrl[3]), .cpha(ctrl[2]), .miso,
    .busy, .done, .sck, .mosi, .rx_byte
  );
endmodule

// File: tb/spi_master_regs_test.sv
`timescale 1ns/1ps
module spi_master_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // slave model state
  int       arm_seq = 0, seen_seq = 0;
  bit       cur_cpha = 0;
  logic [7:0] slave = 8'h00;
  int       edges = 0, gap_ctr = 0, gap2 = 0;
  logic [7:0] cap = 8'h00;
  logic     sck_prev = 1'b0;

  always #10 clk = ~clk;

  spi_master_regs uut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .irq, .sck, .mosi, .miso
  );

  always @(negedge clk) begin
    if (arm_seq != seen_seq) begin
      seen_seq = arm_seq;
      edges = 0; gap_ctr = 0; gap2 = 0; cap = 8'h00;
      sck_prev = sck;
      miso = slave[7];
    end else begin
      gap_ctr++;
      if (sck != sck_prev) begin
        sck_prev = sck;
        edges++;
        if (edges == 2) gap2 = gap_ctr;
        gap_ctr = 0;
        if (cur_cpha ? (edges % 2 == 0) : (edges % 2 == 1))
          cap = {cap[6:0], mosi};
        if (!cur_cpha && edges % 2 == 0 && edges / 2 < 8) miso = slave[7 - edges / 2];
        if (cur_cpha && edges % 2 == 1) miso = slave[7 - (edges - 1) / 2];
      end
    end
  end

  function automatic int exp_half(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] mk_ctrl(input bit ie, input bit cpol,
                                         input bit cpha, input int rate);
    return {ie, 1'b1, 1'b0, 1'b1, cpol, cpha, 2'(rate)};
  endfunction

  task automatic run_xfer(input logic [7:0] c, input logic [7:0] tx,
                          input logic [7:0] slv);
    wr(2'd0, c);
    cur_cpha = c[2];
    slave = slv;
    arm_seq++;
    @(negedge clk);
    wr(2'd2, tx);
    repeat (16 * exp_half(int'(c[1:0])) + 4) @(negedge clk);
  endtask

  task automatic full_xfer(input bit ie, input bit cpol, input bit cpha,
                           input int rate, input logic [7:0] tx,
                           input logic [7:0] slv);
    logic [7:0] v;
    run_xfer(mk_ctrl(ie, cpol, cpha, rate), tx, slv);
    check("R5 edge count", edges, 16);
    check("R5 rest level", int'(sck), int'(cpol));
    check("R2 half period", gap2, exp_half(rate));
    if (cpha) check("R4 mosi byte", int'(cap), int'(tx));
    else      check("R3 mosi byte", int'(cap), int'(tx));
    check("R8 irq", int'(irq), int'(ie));
    rd(2'd1, v); check("R8 status done", int'(v), 8'h80);
    rd(2'd2, v); check("R11 rx byte", int'(v), int'(slv));
    rd(2'd1, v); check("R9 cleared", int'(v), 8'h00);
    check("R8 irq low", int'(irq), 0);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", int'(v), 0);
    rd(2'd1, v); check("R1 status", int'(v), 0);
    check("R1 sck", int'(sck), 0);
    check("R1 irq", int'(irq), 0);

    // directed: all four clock modes
    full_xfer(1, 0, 0, 0, 8'hA5, 8'h3C);
    full_xfer(0, 1, 0, 1, 8'h81, 8'h7E);
    full_xfer(1, 0, 1, 2, 8'h5A, 8'hC3);
    full_xfer(1, 1, 1, 3, 8'h01, 8'h80);

    // R6: disabled block ignores data writes
    wr(2'd0, 8'h10);
    arm_seq++;
    @(negedge clk);
    wr(2'd2, 8'hFF);
    repeat (40) @(negedge clk);
    check("R6 no edges", edges, 0);
    rd(2'd1, v); check("R6 status", int'(v), 0);

    // R7: collision
    wr(2'd0, mk_ctrl(0, 0, 0, 1));
    cur_cpha = 0; slave = 8'h99; arm_seq++;
    @(negedge clk);
    wr(2'd2, 8'hC6);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h3C);
    rd(2'd1, v); check("R7 wcol set", int'(v), 8'h40);
    repeat (40) @(negedge clk);
    check("R7 byte kept", int'(cap), 8'hC6);
    check("R7 edge count", edges, 16);
    rd(2'd1, v); check("R7 both flags", int'(v), 8'hC0);
    rd(2'd2, v); check("R11 rx after coll", int'(v), 8'h99);
    rd(2'd1, v); check("R9 both cleared", int'(v), 8'h00);

    // R10 / R9: status write ignored, data read without record clears nothing
    run_xfer(mk_ctrl(1, 0, 0, 0), 8'h12, 8'h34);
    wr(2'd1, 8'h00);
    rd(2'd2, v); check("R11 rx", int'(v), 8'h34);
    rd(2'd1, v); check("R10 status write ignored", int'(v), 8'h80);
    check("R8 irq held", int'(irq), 1);
    rd(2'd2, v);
    rd(2'd1, v); check("R9 cleared after record", int'(v), 8'h00);

    // constrained random exchanges
    for (int i = 0; i < 12; i++) begin
      full_xfer(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4),
                8'($urandom), 8'($urandom));
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule